// File: doc/BRIEF.md
# Row-Stationary 1-D Convolution Processing Element

This processing element computes one row of a 1-D convolution. A filter row of up to five signed 8-bit taps is written once into a local weight bank. It is then reused for every output position of the input row, and nothing is re-read from outside. Input activations arrive one per handshake as a stream. Each activation is multiplied by every tap at once. Every product is added into a bank of stationary partial-sum registers, one register for each output position still open. A partial sum therefore stays inside the element until its last tap arrives. That completed sum is then added to a partial sum taken from the neighbouring element and sent downstream. Chaining several elements in this way builds a 2-D convolution out of 1-D rows.

The activation, incoming partial-sum and outgoing partial-sum ports are valid/ready streams. An activation that completes an output window is accepted only in the same cycle as one incoming partial sum. That activation is also held back while the output register carries a result the consumer has not taken. Back-pressure on the output therefore stops the window from advancing. The incoming partial-sum stream is never drained on its own. The weight load port and the tap-count input are plain control pins.

Top module: `rs_conv_pe`

## Requirements
- R1: After reset `psout_valid` is low, `psin_ready` is low while `act_valid` is low, and every tap weight is zero, so an output equals the incoming partial sum alone.
- R2: With effective filter length S, output n equals sum over k = 0..S-1 of w[k]·x[n+k], plus the n-th incoming partial sum. w[k] is the weight loaded at index k, x[i] is the i-th activation of the row, all operands are signed two's complement, and the result wraps to 24 bits.
- R3: A row of W activations, where the last one is flagged by `act_last`, yields exactly max(W−S+1, 0) outputs, in output-position order, and no further output.
- R4: An incoming partial sum is consumed (`psin_valid` and `psin_ready` both high) exactly in the cycles where an activation completing an output window is accepted. It is never consumed at any other time.
- R5: While `psout_valid` is high and `psout_ready` is low, `psout_data` holds its value and stays valid, and an activation that would complete a window is not accepted (`act_ready` low).
- R6: A weight write (`wt_load` high, `wt_idx` < 5) takes effect only between rows, which means no row is open and no activation is accepted in that cycle. A write attempted inside a row is ignored, in that row and in later rows.
- R7: `cfg_taps` is sampled when the first activation of a row is accepted and is held for the whole row. A value of 0 acts as 1, and values above 5 act as 5.
- R8: Accepting the `act_last` activation closes the row and empties the window. No output ever combines activations from two rows.
- R9: The result for a window is valid on `psout_valid` in the cycle right after the activation that completes it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_taps | input | 3 | Filter length for the next row (clamped to 1..5) |
| wt_load | input | 1 | Weight write strobe |
| wt_idx | input | 3 | Tap index being written |
| wt_data | input | 8 | Signed weight value |
| act_valid | input | 1 | Activation stream valid |
| act_ready | output | 1 | Activation stream ready |
| act_data | input | 8 | Signed activation |
| act_last | input | 1 | Marks the final activation of a row |
| psin_valid | input | 1 | Neighbour partial-sum valid |
| psin_ready | output | 1 | Neighbour partial-sum ready |
| psin_data | input | 24 | Signed neighbour partial sum |
| psout_valid | output | 1 | Outgoing partial-sum valid |
| psout_ready | input | 1 | Outgoing partial-sum ready |
| psout_data | output | 24 | Signed outgoing partial sum |

## Verification
The handshake signals `act_ready` and `psin_ready` are combinational, so the bench judges them in the same cycle it drives the valids. A completed window must show up on `psout_valid` one cycle after its final activation is accepted, so the bench tests that flag on the following cycle. Under a stalled output, the held data is compared with its value one cycle earlier. Inputs change on the falling clock edge, and every sample is taken 1 ns later, so each comparison sees settled values that belong to a single rising edge.

// File: rtl/rs_pe_pkg.sv
package rs_pe_pkg;
  localparam int unsigned PE_DATA_W   = 8;
  localparam int unsigned PE_ACC_W    = 24;
  localparam int unsigned PE_MAX_TAPS = 5;
endpackage

// File: rtl/rs_pe_wbank.sv
module rs_pe_wbank #(
  parameter int DW       = 8,
  parameter int MAX_TAPS = 5,
  parameter int IDX_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_allow,
  input  logic                   wr_req,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DW-1:0]          wr_data,
  output logic [MAX_TAPS*DW-1:0] taps_flat
);
  for (genvar g = 0; g < MAX_TAPS; g++) begin : g_tap
    logic [DW-1:0] tap_q;
    always_ff @(posedge clk) begin
      if (!rst_n) tap_q <= '0;
      else if (wr_req && wr_allow && int'(wr_idx) == g) tap_q <= wr_data;
    end
    assign taps_flat[g*DW +: DW] = tap_q;
  end

  // R6: weights cannot move while writes are locked out
  a_r6_weights_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(taps_flat));
endmodule

// File: rtl/rs_pe_accum.sv
module rs_pe_accum #(
  parameter int DW       = 8,
  parameter int ACC_W    = 24,
  parameter int MAX_TAPS = 5,
  parameter int TAP_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic [DW-1:0]          act,
  input  logic [MAX_TAPS*DW-1:0] taps_flat,
  input  logic [TAP_W-1:0]       taps_n,
  output logic [ACC_W-1:0]       done_sum
);
  localparam int PW = 2 * DW;

  logic signed [ACC_W-1:0] prod [MAX_TAPS];
  logic signed [ACC_W-1:0] base [MAX_TAPS];
  logic signed [ACC_W-1:0] part_q [MAX_TAPS];

  for (genvar g = 0; g < MAX_TAPS; g++) begin : g_mul
    logic signed [PW-1:0] p;
    assign p = $signed(taps_flat[g*DW +: DW]) * $signed(act);
    assign prod[g] = {{(ACC_W-PW){p[PW-1]}}, p};
  end

  // base[j]: running sum of a position that has seen j activations
  always_comb begin
    base[0] = '0;
    for (int j = 1; j < MAX_TAPS; j++) base[j] = part_q[j];
  end

  always_ff @(posedge clk) begin
    part_q[0] <= '0;
    if (!rst_n) begin
      for (int j = 1; j < MAX_TAPS; j++) part_q[j] <= '0;
    end else if (step) begin
      for (int j = 1; j < MAX_TAPS; j++) part_q[j] <= base[j-1] + prod[j-1];
    end
  end

  always_comb begin
    done_sum = prod[0];
    for (int k = 0; k < MAX_TAPS; k++)
      if (k + 1 == int'(taps_n)) done_sum = base[k] + prod[k];
  end
endmodule

// File: rtl/rs_pe_ctrl.sv
module rs_pe_ctrl #(
  parameter int MAX_TAPS = 5,
  parameter int TAP_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] cfg_taps,
  input  logic             act_valid,
  input  logic             act_last,
  input  logic             psin_valid,
  input  logic             out_busy,
  input  logic             out_take,
  output logic             act_ready,
  output logic             psin_ready,
  output logic             act_fire,
  output logic             win_done,
  output logic             wr_allow,
  output logic [TAP_W-1:0] taps_n
);
  logic             row_open_q;
  logic [TAP_W-1:0] taps_q, fill_q, taps_live;
  logic             completes, out_free;

  always_comb begin
    if (cfg_taps == '0) taps_live = TAP_W'(1);
    else if (int'(cfg_taps) > MAX_TAPS) taps_live = TAP_W'(MAX_TAPS);
    else taps_live = cfg_taps;
  end

  assign taps_n     = row_open_q ? taps_q : taps_live;
  assign completes  = ({1'b0, fill_q} + 1'b1) >= {1'b0, taps_n};
  assign out_free   = !out_busy || out_take;
  assign act_ready  = out_free && (!completes || psin_valid);
  assign psin_ready = act_valid && out_free && completes;
  assign act_fire   = act_valid && act_ready;
  assign win_done   = act_fire && completes;
  assign wr_allow   = !row_open_q && !act_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open_q <= 1'b0;
      taps_q     <= TAP_W'(1);
      fill_q     <= '0;
    end else if (act_fire) begin
      row_open_q <= !act_last;
      taps_q     <= taps_n;
      if (act_last)       fill_q <= '0;
      else if (completes) fill_q <= taps_n - 1'b1;
      else                fill_q <= fill_q + 1'b1;
    end
  end

  // R8: the closing activation empties the window
  a_r8_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire && act_last |=> !row_open_q && fill_q == '0);
  // R7: the window never holds a full filter's worth without emitting
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q < taps_n);
  // R4: a neighbour sum is only taken alongside an accepted activation
  a_r4_psin_paired: assert property (@(posedge clk) disable iff (!rst_n)
    psin_valid && psin_ready |-> act_fire);
endmodule

// File: rtl/rs_conv_pe.sv
module rs_conv_pe
  import rs_pe_pkg::*;
#(
  parameter int DW       = PE_DATA_W,
  parameter int ACC_W    = PE_ACC_W,
  parameter int MAX_TAPS = PE_MAX_TAPS,
  localparam int TAP_W   = $clog2(MAX_TAPS + 1),
  localparam int IDX_W   = $clog2(MAX_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] cfg_taps,
  input  logic             wt_load,
  input  logic [IDX_W-1:0] wt_idx,
  input  logic [DW-1:0]    wt_data,
  input  logic             act_valid,
  output logic             act_ready,
  input  logic [DW-1:0]    act_data,
  input  logic             act_last,
  input  logic             psin_valid,
  output logic             psin_ready,
  input  logic [ACC_W-1:0] psin_data,
  output logic             psout_valid,
  input  logic             psout_ready,
  output logic [ACC_W-1:0] psout_data
);
  logic                   act_fire, win_done, wr_allow;
  logic [TAP_W-1:0]       taps_n;
  logic [MAX_TAPS*DW-1:0] taps_flat;
  logic [ACC_W-1:0]       done_sum;

  rs_pe_ctrl #(.MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_taps(cfg_taps),
    .act_valid(act_valid), .act_last(act_last), .psin_valid(psin_valid),
    .out_busy(psout_valid), .out_take(psout_ready),
    .act_ready(act_ready), .psin_ready(psin_ready), .act_fire(act_fire),
    .win_done(win_done), .wr_allow(wr_allow), .taps_n(taps_n)
  );

  rs_pe_wbank #(.DW(DW), .MAX_TAPS(MAX_TAPS), .IDX_W(IDX_W)) u_wbank (
    .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow), .wr_req(wt_load),
    .wr_idx(wt_idx), .wr_data(wt_data), .taps_flat(taps_flat)
  );

  rs_pe_accum #(.DW(DW), .ACC_W(ACC_W), .MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .step(act_fire), .act(act_data),
    .taps_flat(taps_flat), .taps_n(taps_n), .done_sum(done_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psout_valid <= 1'b0;
      psout_data  <= '0;
    end else if (win_done) begin
      psout_valid <= 1'b1;
      psout_data  <= done_sum + psin_data;
    end else if (psout_ready) begin
      psout_valid <= 1'b0;
    end
  end

  // R5: a stalled result stays put
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    psout_valid && !psout_ready |=> psout_valid && $stable(psout_data));
  // R9: a completed window is presented on the next cycle
  a_r9_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> psout_valid);
endmodule

// File: tb/sim_rs_conv_pe.sv
`timescale 1ns/1ps
module sim_rs_conv_pe;
  localparam int DW = 8, ACC_W = 24, MAXT = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] cfg_taps = '0;
  logic wt_load = 1'b0;
  logic [2:0] wt_idx = '0;
  logic [DW-1:0] wt_data = '0;
  logic act_valid = 1'b0, act_last = 1'b0, psin_valid = 1'b0, psout_ready = 1'b0;
  logic [DW-1:0] act_data = '0;
  logic [ACC_W-1:0] psin_data = '0;
  logic act_ready, psin_ready, psout_valid;
  logic [ACC_W-1:0] psout_data;

  rs_conv_pe u0 (
    .clk(clk), .rst_n(rst_n), .cfg_taps(cfg_taps), .wt_load(wt_load),
    .wt_idx(wt_idx), .wt_data(wt_data), .act_valid(act_valid),
    .act_ready(act_ready), .act_data(act_data), .act_last(act_last),
    .psin_valid(psin_valid), .psin_ready(psin_ready), .psin_data(psin_data),
    .psout_valid(psout_valid), .psout_ready(psout_ready), .psout_data(psout_data)
  );

  int n_total = 0, n_fail = 0;
  int acts [64];
  logic [ACC_W-1:0] psins [64];
  int ws [MAXT];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] expect_out(input int n, input int s);
    longint sum = 0;
    for (int k = 0; k < s; k++) sum += longint'(ws[k]) * longint'(acts[n+k]);
    return ACC_W'(sum) + psins[n];
  endfunction

  task automatic fill_row(input int w, input bit big);
    for (int i = 0; i < w; i++) begin
      acts[i]  = int'($urandom_range(0, 255)) - 128;
      psins[i] = big ? ACC_W'($urandom) : ACC_W'(int'($urandom_range(0, 2000)) - 1000);
    end
  endtask

  task automatic load_weights(input int v0, input int v1, input int v2, input int v3, input int v4);
    int vals [MAXT];
    vals = '{v0, v1, v2, v3, v4};
    for (int k = 0; k < MAXT; k++) begin
      @(negedge clk);
      wt_load = 1'b1; wt_idx = 3'(k); wt_data = DW'(vals[k]);
      ws[k] = vals[k];
    end
    @(negedge clk);
    wt_load = 1'b0;
  endtask

  task automatic run_row(input int w, input int cfg, input bit mid_load,
                         input bit vary_cfg, input int rdy_pct);
    int s, nout, ai, pi, oi, cyc;
    bit prev_hold, prev_done, a_fire, p_fire, compl;
    logic [ACC_W-1:0] prev_data;
    s = (cfg < 1) ? 1 : ((cfg > MAXT) ? MAXT : cfg);
    nout = (w >= s) ? w - s + 1 : 0;
    ai = 0; pi = 0; oi = 0; cyc = 0;
    prev_hold = 0; prev_done = 0; prev_data = '0;
    while ((ai < w || oi < nout) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      act_valid   = (ai < w) && ($urandom_range(0, 99) < 80);
      act_data    = DW'(acts[(ai < w) ? ai : 0]);
      act_last    = (ai == w - 1);
      psin_valid  = (pi < nout) && ($urandom_range(0, 99) < 85);
      psin_data   = psins[(pi < nout) ? pi : 0];
      psout_ready = ($urandom_range(0, 99) < rdy_pct);
      cfg_taps    = (vary_cfg && ai > 0) ? 3'($urandom_range(0, 7)) : 3'(cfg);
      wt_load     = mid_load && (ai == 2);
      wt_idx      = 3'($urandom_range(0, 4));
      wt_data     = DW'($urandom);
      #1;
      if (prev_hold) chk(psout_valid && psout_data == prev_data, "R5 stalled output held",
                         longint'(psout_data), longint'(prev_data));
      if (prev_done) chk(psout_valid, "R9 result valid next cycle", psout_valid, 1);
      if (psout_valid && psout_ready) begin
        if (oi < nout) chk(psout_data == expect_out(oi, s), "R2 R8 output value",
                           longint'(psout_data), longint'(expect_out(oi, s)));
        else chk(1'b0, "R3 surplus output", oi, nout);
        oi++;
      end
      prev_hold = psout_valid && !psout_ready;
      prev_data = psout_data;
      compl  = (ai + 1 >= s);
      a_fire = act_valid && act_ready;
      p_fire = psin_valid && psin_ready;
      if (psout_valid && !psout_ready && act_valid && compl)
        chk(!act_ready, "R5 window held under back-pressure", act_ready, 0);
      if (p_fire || (a_fire && compl))
        chk(p_fire == (a_fire && compl), "R4 psin consumed with completing activation",
            p_fire, a_fire && compl);
      prev_done = a_fire && compl;
      if (a_fire) ai++;
      if (p_fire) pi++;
    end
    if (cyc >= 3000) chk(1'b0, "R3 row stalled", ai, w);
    @(negedge clk);
    act_valid = 1'b0; psin_valid = 1'b0; psout_ready = 1'b1; wt_load = 1'b0; act_last = 1'b0;
    #1;
    chk(!psout_valid, "R3 no output after row", psout_valid, 0);
    chk(oi == nout, "R3 output count", oi, nout);
  endtask

  initial begin
    #600000;
    n_total++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < MAXT; k++) ws[k] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!psout_valid, "R1 psout_valid low in reset", psout_valid, 0);
    chk(!psin_ready, "R1 psin_ready low without activation", psin_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: zero weights after reset pass only the neighbour sum
    fill_row(6, 0);
    run_row(6, 3, 0, 0, 100);

    load_weights(3, -2, 5, 1, -7);
    for (int t = 1; t <= MAXT; t++) begin
      fill_row(12, 0);
      run_row(12, t, 0, 0, 70);
    end

    // R7: clamping of out-of-range tap counts
    fill_row(8, 0); run_row(8, 0, 0, 0, 100);
    fill_row(8, 0); run_row(8, 7, 0, 0, 60);

    // R3 R8: short row, then an exact-length row starting with an empty window
    fill_row(2, 0); run_row(2, 4, 0, 0, 100);
    fill_row(4, 0); run_row(4, 4, 0, 0, 100);
    fill_row(1, 0); run_row(1, 1, 0, 0, 100);

    // R2: extremes and wrap of the 24-bit sum
    load_weights(-128, -128, -128, -128, -128);
    for (int i = 0; i < 9; i++) begin acts[i] = -128; psins[i] = 24'h7FFFF0; end
    run_row(9, 5, 0, 0, 100);
    load_weights(127, -128, 127, -128, 127);
    for (int i = 0; i < 9; i++) begin acts[i] = (i % 2 == 0) ? 127 : -128; psins[i] = 24'h800005; end
    run_row(9, 5, 0, 0, 40);

    // R6: writes inside a row are dropped, in this row and the next
    load_weights(1, 2, -3, 4, -5);
    fill_row(10, 0); run_row(10, 3, 1, 0, 80);
    fill_row(10, 0); run_row(10, 5, 1, 0, 80);
    fill_row(10, 0); run_row(10, 5, 0, 0, 80);

    // R7: tap count changed mid-row is not picked up
    fill_row(11, 0); run_row(11, 4, 0, 1, 80);
    fill_row(11, 0); run_row(11, 2, 0, 1, 50);

    // heavy back-pressure
    fill_row(16, 1); run_row(16, 3, 0, 0, 15);

    for (int r = 0; r < 20; r++) begin
      if (r % 5 == 0)
        load_weights(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                     int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                     int'($urandom_range(0, 255)) - 128);
      begin
        int w;
        w = int'($urandom_range(1, 30));
        fill_row(w, r[0]);
        run_row(w, int'($urandom_range(0, 7)), 0, r[1], int'($urandom_range(20, 100)));
      end
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule